// File: doc/BRIEF.md
# Re-timer Hop-Count Forwarder

This block sits inside a link re-timer between its two ports, called side A and side B. During port configuration, each side sends low-speed 8-bit PHY Ready messages. The block takes each message in on one side and forwards it out of the other side. When the link is set up for two lanes and the message does not ask for re-timer addressing, the block adds one to a 3-bit hop field before it forwards the message. The field then tells the far end how many re-timers lie on the path. A message is held in a one-entry register for each direction. It goes out only once both ports report that they are ready, so every forwarded message is delayed by at least one cycle.

One bit of each message tells the block which of its two sides faces the host. The block also keeps the hop value last received from each side. From these two values it derives the total number of re-timers on the path, and it presents that total on a registered output for the local skip-insertion logic. The skip logic multiplies its normal count of skip ordered sets by this number in the lower-rate two-lane mode.

Top module: `retimer_announce_fwd`

## Requirements
- R1: In reset and directly after it, `a_tx_vld` and `b_tx_vld` are 0, `hop_total` is 0 and `host_on_b` is 0.
- R2: A message taken in on one side (`x_rx_vld` high at a rising edge) is presented on the other side's `tx_msg` with `tx_vld` high for exactly one cycle. This happens after the next rising edge at which both `a_rdy` and `b_rdy` are high. A message is never sent back out of the side it came in on.
- R3: While `a_rdy` or `b_rdy` is low, a held message is not sent. It goes out after the first edge at which both are high.
- R4: When `two_lane` is 1 and bit 7 of the message is 0, the hop field (bits [4:2]) of the forwarded message is the received field plus one. All other bits are unchanged.
- R5: If the received hop field is already 3'b111, it is forwarded as 3'b111. It does not wrap.
- R6: A message with bit 7 set (the host asks to address re-timers) is forwarded bit for bit unchanged, even when `two_lane` is 1.
- R7: When `two_lane` is 0, every message is forwarded unchanged, and `hop_total` keeps its value.
- R8: Bit 6 of a received message set to 1 means the sender faces the host. A message on side A sets `host_on_b` to the inverse of its bit 6. A message on side B sets `host_on_b` to its bit 6. If both sides take a message in the same cycle, side A decides.
- R9: `hop_total` is 0 until the first counted message. A counted message has `two_lane` at 1 and bit 7 at 0. After that, `hop_total` equals min(7, last hop field received on A + last hop field received on B + 1), using the fields as received, and it is updated at the capture edge.
- R10: A new message taken in while an older one is still held replaces it, and only the newer one is sent. A new message taken in at the same edge at which the held one is sent is kept and sent next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_lane | input | 1 | Link configured for two-lane operation |
| a_rdy | input | 1 | Side A port is ready |
| b_rdy | input | 1 | Side B port is ready |
| a_rx_msg | input | 8 | Message received on side A |
| a_rx_vld | input | 1 | `a_rx_msg` is valid this cycle |
| b_rx_msg | input | 8 | Message received on side B |
| b_rx_vld | input | 1 | `b_rx_msg` is valid this cycle |
| a_tx_msg | output | 8 | Message sent out of side A (came from B) |
| a_tx_vld | output | 1 | `a_tx_msg` is valid this cycle |
| b_tx_msg | output | 8 | Message sent out of side B (came from A) |
| b_tx_vld | output | 1 | `b_tx_msg` is valid this cycle |
| host_on_b | output | 1 | 1 when the host lies beyond side B |
| hop_total | output | 3 | Re-timers on the path, for skip insertion |

## Verification
Two pairs of functions can land on the same clock edge. In the first pair, one edge both sends the held message and takes in a new one. The bench provokes this by sending two messages on side A in consecutive cycles with both ports ready. It judges the result by seeing the older message, then the newer one, on side B in back-to-back cycles. In the second pair, both sides take in a message at once, which sets up a conflict over orientation. The bench sends opposing bit-6 claims on A and B together. It expects `host_on_b` to follow side A, and both messages to be forwarded, each with its own hop increment.

// File: rtl/retimer_fwd_pkg.sv
package retimer_fwd_pkg;

  localparam int unsigned DIR_A_TO_B = 0;
  localparam int unsigned DIR_B_TO_A = 1;

  // add one, stop at the ceiling
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned ceil);
    return (v >= ceil) ? ceil : v + 1;
  endfunction

  // upstream hops + downstream hops + this re-timer, stop at the ceiling
  function automatic int unsigned sat_path_total(input int unsigned up, input int unsigned dn,
                                                 input int unsigned ceil);
    int unsigned s;
    s = up + dn + 1;
    return (s >= ceil) ? ceil : s;
  endfunction

endpackage

// File: rtl/retimer_fwd_path.sv
module retimer_fwd_path
  import retimer_fwd_pkg::*;
#(
  parameter int MSG_W    = 8,
  parameter int HOP_LSB  = 2,
  parameter int HOP_W    = 3,
  parameter int ADDR_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_lane,
  input  logic             fwd_ok,
  input  logic [MSG_W-1:0] rx_msg,
  input  logic             rx_vld,
  output logic [MSG_W-1:0] tx_msg,
  output logic             tx_vld,
  output logic             held,
  output logic             counted,
  output logic [HOP_W-1:0] raw_hops
);

  localparam int unsigned HOP_MAX = (1 << HOP_W) - 1;

  logic [MSG_W-1:0] held_msg;
  logic [MSG_W-1:0] cap_msg;
  logic [HOP_W-1:0] bumped;
  logic             fire;

  assign raw_hops = rx_msg[HOP_LSB +: HOP_W];
  assign counted  = rx_vld && two_lane && !rx_msg[ADDR_BIT];
  assign bumped   = HOP_W'(sat_inc(32'(raw_hops), HOP_MAX));

  always_comb begin
    cap_msg = rx_msg;
    if (counted) cap_msg[HOP_LSB +: HOP_W] = bumped;
  end

  assign fire = held && fwd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_msg <= '0;
      tx_vld   <= 1'b0;
      tx_msg   <= '0;
    end else begin
      if (rx_vld) begin
        held     <= 1'b1;
        held_msg <= cap_msg;
      end else if (fire) begin
        held <= 1'b0;
      end
      tx_vld <= fire;
      if (fire) tx_msg <= held_msg;
    end
  end

endmodule

// File: rtl/retimer_fwd_orient.sv
module retimer_fwd_orient (
  input  logic clk,
  input  logic rst_n,
  input  logic a_vld,
  input  logic a_host_flag,
  input  logic b_vld,
  input  logic b_host_flag,
  output logic host_on_b
);

  always_ff @(posedge clk) begin
    if (!rst_n)     host_on_b <= 1'b0;
    else if (a_vld) host_on_b <= !a_host_flag;
    else if (b_vld) host_on_b <= b_host_flag;
  end

endmodule

// File: rtl/retimer_fwd_tally.sv
module retimer_fwd_tally
  import retimer_fwd_pkg::*;
#(
  parameter int HOP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_cnt,
  input  logic [HOP_W-1:0] a_hops,
  input  logic             b_cnt,
  input  logic [HOP_W-1:0] b_hops,
  output logic [HOP_W-1:0] hop_total
);

  localparam int unsigned HOP_MAX = (1 << HOP_W) - 1;

  logic [HOP_W-1:0] a_last, b_last, a_next, b_next;
  logic             seen;

  assign a_next = a_cnt ? a_hops : a_last;
  assign b_next = b_cnt ? b_hops : b_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_last    <= '0;
      b_last    <= '0;
      seen      <= 1'b0;
      hop_total <= '0;
    end else if (a_cnt || b_cnt) begin
      a_last    <= a_next;
      b_last    <= b_next;
      seen      <= 1'b1;
      hop_total <= HOP_W'(sat_path_total(32'(a_next), 32'(b_next), HOP_MAX));
    end else if (!seen) begin
      hop_total <= '0;
    end
  end

endmodule

// File: rtl/retimer_announce_fwd.sv
module retimer_announce_fwd
  import retimer_fwd_pkg::*;
#(
  parameter int MSG_W      = 8,
  parameter int HOP_LSB    = 2,
  parameter int HOP_W      = 3,
  parameter int ORIENT_BIT = 6,
  parameter int ADDR_BIT   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_lane,
  input  logic             a_rdy,
  input  logic             b_rdy,
  input  logic [MSG_W-1:0] a_rx_msg,
  input  logic             a_rx_vld,
  input  logic [MSG_W-1:0] b_rx_msg,
  input  logic             b_rx_vld,
  output logic [MSG_W-1:0] a_tx_msg,
  output logic             a_tx_vld,
  output logic [MSG_W-1:0] b_tx_msg,
  output logic             b_tx_vld,
  output logic             host_on_b,
  output logic [HOP_W-1:0] hop_total
);

  logic             fwd_ok;
  logic [MSG_W-1:0] rx_m    [2];
  logic             rx_v    [2];
  logic [MSG_W-1:0] tx_m    [2];
  logic             tx_v    [2];
  logic             held_v  [2];
  logic             cnt_v   [2];
  logic [HOP_W-1:0] hops_v  [2];

  // named events for the checker
  logic a2b_held, b2a_held;

  assign fwd_ok = a_rdy && b_rdy;

  assign rx_m[DIR_A_TO_B] = a_rx_msg;
  assign rx_v[DIR_A_TO_B] = a_rx_vld;
  assign rx_m[DIR_B_TO_A] = b_rx_msg;
  assign rx_v[DIR_B_TO_A] = b_rx_vld;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    retimer_fwd_path #(
      .MSG_W(MSG_W), .HOP_LSB(HOP_LSB), .HOP_W(HOP_W), .ADDR_BIT(ADDR_BIT)
    ) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .two_lane (two_lane),
      .fwd_ok   (fwd_ok),
      .rx_msg   (rx_m[d]),
      .rx_vld   (rx_v[d]),
      .tx_msg   (tx_m[d]),
      .tx_vld   (tx_v[d]),
      .held     (held_v[d]),
      .counted  (cnt_v[d]),
      .raw_hops (hops_v[d])
    );
  end

  assign b_tx_msg = tx_m[DIR_A_TO_B];
  assign b_tx_vld = tx_v[DIR_A_TO_B];
  assign a_tx_msg = tx_m[DIR_B_TO_A];
  assign a_tx_vld = tx_v[DIR_B_TO_A];
  assign a2b_held = held_v[DIR_A_TO_B];
  assign b2a_held = held_v[DIR_B_TO_A];

  retimer_fwd_orient u_orient (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_vld       (a_rx_vld),
    .a_host_flag (a_rx_msg[ORIENT_BIT]),
    .b_vld       (b_rx_vld),
    .b_host_flag (b_rx_msg[ORIENT_BIT]),
    .host_on_b   (host_on_b)
  );

  retimer_fwd_tally #(.HOP_W(HOP_W)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_cnt     (cnt_v[DIR_A_TO_B]),
    .a_hops    (hops_v[DIR_A_TO_B]),
    .b_cnt     (cnt_v[DIR_B_TO_A]),
    .b_hops    (hops_v[DIR_B_TO_A]),
    .hop_total (hop_total)
  );

endmodule

// File: rtl/retimer_announce_fwd_chk.sv
module retimer_announce_fwd_chk #(
  parameter int MSG_W      = 8,
  parameter int HOP_LSB    = 2,
  parameter int HOP_W      = 3,
  parameter int ORIENT_BIT = 6,
  parameter int ADDR_BIT   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             two_lane,
  input logic             a_rdy,
  input logic             b_rdy,
  input logic [MSG_W-1:0] a_rx_msg,
  input logic             a_rx_vld,
  input logic             b_rx_vld,
  input logic [MSG_W-1:0] b_tx_msg,
  input logic             b_tx_vld,
  input logic             a_tx_vld,
  input logic             host_on_b,
  input logic [HOP_W-1:0] hop_total,
  input logic             a2b_held
);

  localparam logic [HOP_W-1:0] HOP_TOP = '1;

  AST_WAIT_BOTH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (a_tx_vld || b_tx_vld) |-> $past(a_rdy && b_rdy)); // R3

  AST_SEND_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !a2b_held |=> !b_tx_vld); // R2

  AST_HOP_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rx_vld && two_lane && !a_rx_msg[ADDR_BIT] && a_rx_msg[HOP_LSB +: HOP_W] != HOP_TOP)
      ##1 (a_rdy && b_rdy)
    |=> b_tx_vld && b_tx_msg[HOP_LSB +: HOP_W] == $past(a_rx_msg[HOP_LSB +: HOP_W], 2) + 1'b1); // R4

  AST_HOP_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rx_vld && two_lane && !a_rx_msg[ADDR_BIT] && a_rx_msg[HOP_LSB +: HOP_W] == HOP_TOP)
      ##1 (a_rdy && b_rdy)
    |=> b_tx_vld && b_tx_msg == $past(a_rx_msg, 2)); // R5

  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rx_vld && a_rx_msg[ADDR_BIT]) ##1 (a_rdy && b_rdy)
    |=> b_tx_vld && b_tx_msg == $past(a_rx_msg, 2)); // R6

  AST_ONE_LANE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rx_vld && !two_lane) ##1 (a_rdy && b_rdy)
    |=> b_tx_vld && b_tx_msg == $past(a_rx_msg, 2)); // R7

  AST_SIDE_A_ORIENT: assert property (@(posedge clk) disable iff (!rst_n)
    a_rx_vld |=> host_on_b == !$past(a_rx_msg[ORIENT_BIT])); // R8

  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rx_vld && two_lane && !a_rx_msg[ADDR_BIT]) |=> hop_total != '0); // R9

  AST_QUIET_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_lane && !b_rx_vld) |=> $stable(hop_total)); // R7

endmodule

bind retimer_announce_fwd retimer_announce_fwd_chk #(
  .MSG_W(MSG_W), .HOP_LSB(HOP_LSB), .HOP_W(HOP_W),
  .ORIENT_BIT(ORIENT_BIT), .ADDR_BIT(ADDR_BIT)
) u_chk (.*);

// File: tb/retimer_announce_fwd_test.sv
module retimer_announce_fwd_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       two_lane = 1'b1;
  logic       a_rdy = 1'b1, b_rdy = 1'b1;
  logic [7:0] a_rx_msg = '0, b_rx_msg = '0;
  logic       a_rx_vld = 1'b0, b_rx_vld = 1'b0;
  logic [7:0] a_tx_msg, b_tx_msg;
  logic       a_tx_vld, b_tx_vld, host_on_b;
  logic [2:0] hop_total;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  retimer_announce_fwd uut (
    .clk(clk), .rst_n(rst_n), .two_lane(two_lane), .a_rdy(a_rdy), .b_rdy(b_rdy),
    .a_rx_msg(a_rx_msg), .a_rx_vld(a_rx_vld), .b_rx_msg(b_rx_msg), .b_rx_vld(b_rx_vld),
    .a_tx_msg(a_tx_msg), .a_tx_vld(a_tx_vld), .b_tx_msg(b_tx_msg), .b_tx_vld(b_tx_vld),
    .host_on_b(host_on_b), .hop_total(hop_total)
  );

  // {side(0=A,1=B), two_lane, sent msg, expected forwarded msg, expected host_on_b, expected hop_total}
  // hop field is bits [4:2]; bit 7 = addressing; bit 6 = sender faces host
  localparam logic [21:0] VEC [12] = '{
    {1'b0, 1'b1, 8'h40, 8'h44, 1'b0, 3'd1},  // R4 R8 R9
    {1'b1, 1'b1, 8'h03, 8'h07, 1'b0, 3'd1},  // R4 R8
    {1'b0, 1'b1, 8'h51, 8'h55, 1'b0, 3'd5},  // R4 R9
    {1'b1, 1'b1, 8'h08, 8'h0C, 1'b0, 3'd7},  // R4 R9
    {1'b0, 1'b1, 8'h1C, 8'h1C, 1'b1, 3'd7},  // R5 R8
    {1'b0, 1'b1, 8'hC4, 8'hC4, 1'b0, 3'd7},  // R6
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 3'd7},  // R7
    {1'b1, 1'b1, 8'h40, 8'h44, 1'b1, 3'd7},  // R9 saturation
    {1'b0, 1'b1, 8'h44, 8'h48, 1'b0, 3'd2},  // R9 drop
    {1'b1, 1'b0, 8'hFF, 8'hFF, 1'b1, 3'd2},  // R7
    {1'b1, 1'b1, 8'hA6, 8'hA6, 1'b0, 3'd2},  // R6 R8
    {1'b1, 1'b1, 8'h12, 8'h16, 1'b0, 3'd6}   // R4 R9
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input logic side, input logic [7:0] m);
    if (side) begin b_rx_msg = m; b_rx_vld = 1'b1; end
    else      begin a_rx_msg = m; a_rx_vld = 1'b1; end
  endtask

  task automatic idle();
    a_rx_vld = 1'b0;
    b_rx_vld = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 b_tx_vld", {7'd0, b_tx_vld}, 8'd0);
    check("R1 a_tx_vld", {7'd0, a_tx_vld}, 8'd0);
    check("R1 hop_total", {5'd0, hop_total}, 8'd0);
    check("R1 host_on_b", {7'd0, host_on_b}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset hop", {5'd0, hop_total}, 8'd0);

    // table walk: ports ready, one message at a time
    for (int i = 0; i < 12; i++) begin
      logic [21:0] v;
      v = VEC[i];
      two_lane = v[20];
      put(v[21], v[19:12]);
      @(negedge clk);
      idle();
      @(negedge clk);
      if (v[21]) begin
        check("R2 a_tx_vld", {7'd0, a_tx_vld}, 8'd1);
        check("R4-path a_tx_msg", a_tx_msg, v[11:4]);
        check("R2 no echo b_tx_vld", {7'd0, b_tx_vld}, 8'd0);
      end else begin
        check("R2 b_tx_vld", {7'd0, b_tx_vld}, 8'd1);
        check("R4-path b_tx_msg", b_tx_msg, v[11:4]);
        check("R2 no echo a_tx_vld", {7'd0, a_tx_vld}, 8'd0);
      end
      check("R8 host_on_b", {7'd0, host_on_b}, {7'd0, v[3]});
      check("R9 hop_total", {5'd0, hop_total}, {5'd0, v[2:0]});
      @(negedge clk);
      check("R2 single pulse", {6'd0, a_tx_vld, b_tx_vld}, 8'd0);
    end

    // R3: hold while side A not ready
    two_lane = 1'b1;
    a_rdy = 1'b0;
    put(1'b0, 8'h40);
    @(negedge clk);
    idle();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3 held while not ready", {7'd0, b_tx_vld}, 8'd0);
    end
    a_rdy = 1'b1;
    @(negedge clk);
    check("R3 released vld", {7'd0, b_tx_vld}, 8'd1);
    check("R3 released msg", b_tx_msg, 8'h44);
    @(negedge clk);
    check("R3 one pulse", {7'd0, b_tx_vld}, 8'd0);

    // R10: newer message replaces a held one
    b_rdy = 1'b0;
    put(1'b0, 8'h00);
    @(negedge clk);
    put(1'b0, 8'h04);
    @(negedge clk);
    idle();
    @(negedge clk);
    check("R10 nothing while held", {7'd0, b_tx_vld}, 8'd0);
    b_rdy = 1'b1;
    @(negedge clk);
    check("R10 replaced vld", {7'd0, b_tx_vld}, 8'd1);
    check("R10 replaced msg", b_tx_msg, 8'h08);
    @(negedge clk);
    check("R10 old one dropped", {7'd0, b_tx_vld}, 8'd0);

    // R10: capture and send on the same edge
    put(1'b0, 8'h00);
    @(negedge clk);
    put(1'b0, 8'h08);
    @(negedge clk);
    idle();
    check("R10 first vld", {7'd0, b_tx_vld}, 8'd1);
    check("R10 first msg", b_tx_msg, 8'h04);
    @(negedge clk);
    check("R10 second vld", {7'd0, b_tx_vld}, 8'd1);
    check("R10 second msg", b_tx_msg, 8'h0C);
    @(negedge clk);
    check("R10 then quiet", {7'd0, b_tx_vld}, 8'd0);
    check("R8 side A bit6=0", {7'd0, host_on_b}, 8'd1);

    // R8: both sides claim host in the same cycle, side A decides
    put(1'b0, 8'h40);
    put(1'b1, 8'h40);
    @(negedge clk);
    idle();
    check("R8 side A wins", {7'd0, host_on_b}, 8'd0);
    check("R9 both fields zero", {5'd0, hop_total}, 8'd1);
    @(negedge clk);
    check("R2 both directions a", {a_tx_vld, a_tx_msg[6:0]}, 8'hC4);
    check("R2 both directions b", {b_tx_vld, b_tx_msg[6:0]}, 8'hC4);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule